// File: doc/BRIEF.md
# Timer Channel with Compare-Match Clear

A single 16-bit up-counter channel with two general compare registers, A and B. The counter advances by one in every cycle where the external count-enable strobe is high and the channel's run bit is set. After reset the channel runs freely: it counts up, wraps from 0xFFFF to 0x0000, sets a sticky overflow flag and keeps counting. A 2-bit clear-select field turns the channel into a periodic counter. In that mode a match on compare register A, or on compare register B, returns the counter to zero.

Each of the three events (overflow, match A, match B) has a sticky status flag and an interrupt enable of its own. The single interrupt request output is high while any enabled flag is set. Software reaches the channel over a simple register bus. It has a synchronous write port and a combinational read port, each with its own address, and through them it reads and writes the run bit, the clear select, the status flags, the interrupt enables, the counter and both compare registers.

Register map (by address): 0 run bit (bit 0), 1 clear select (bits 1:0), 2 status, 3 interrupt enables, 4 counter, 5 compare A, 6 compare B. Status and enable registers share one bit layout: bit 0 overflow, bit 1 match A, bit 2 match B.

Top module: `tmr_channel`

## Requirements
- R1: After reset the counter reads 0, both compare registers read 0xFFFF, and the run bit, the clear select, the status and the enables read 0. The interrupt output is low.
- R2: The counter advances by one only in a cycle where cnt_en is high and the run bit (address 0, bit 0) is 1. In every other cycle it holds its value.
- R3: A step from 0xFFFF to 0x0000 sets the overflow flag (status bit 0), and counting continues from 0x0000.
- R4: When the value the counter reaches in a step equals compare A, status bit 1 is set. When it equals compare B, status bit 2 is set. This happens whatever the clear select is.
- R5: With clear select 01, a step whose value reaches compare A loads 0x0000 instead, so the period is compare-A steps.
- R6: With clear select 10, a step whose value reaches compare B loads 0x0000 instead. Clear select 00 and 11 never clear the counter.
- R7: Status flags are sticky. A write to address 2 clears each flag whose data bit is 0 and leaves each flag whose data bit is 1 unchanged. A flag that is set in the same cycle as a clearing write ends up set.
- R8: irq is high exactly while at least one status flag and its matching enable bit (address 3) are both 1.
- R9: A write to the counter address loads the written value. A step in that same cycle is dropped.
- R10: Reads return the register addressed by rd_addr in the same cycle. Unused address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Count-enable strobe, one step per high cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write register address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read register address |
| rd_data | output | 16 | Read data, combinational |
| irq | output | 1 | Interrupt request |

## Verification
If the counter holds a wrong value, the next read of address 4 shows it in the same cycle. If the counter is stepped on a wrong cycle, the fault shows as an off-by-one count after a known number of strobes. A wrong match or wrap decision shows one edge after the step that caused it: a status bit set or missing, or a counter that reads its compare value where it should read zero. A flag that should be sticky but drops, or a clear that acts on the wrong bits, shows at the next status read and on irq, because irq follows the flag registers through logic with no register in between.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  typedef enum logic [1:0] {
    CLR_NONE = 2'b00,
    CLR_ON_A = 2'b01,
    CLR_ON_B = 2'b10,
    CLR_RSVD = 2'b11
  } clr_sel_e;

  localparam int unsigned ADR_RUN   = 0;
  localparam int unsigned ADR_CTRL  = 1;
  localparam int unsigned ADR_STAT  = 2;
  localparam int unsigned ADR_IEN   = 3;
  localparam int unsigned ADR_COUNT = 4;
  localparam int unsigned ADR_CMPA  = 5;
  localparam int unsigned ADR_CMPB  = 6;

  localparam int unsigned NFLAGS  = 3;
  localparam int unsigned FLG_OVF = 0;
  localparam int unsigned FLG_A   = 1;
  localparam int unsigned FLG_B   = 2;
endpackage

// File: rtl/tmr_regs.sv
`timescale 1ns/1ps
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int W  = 16,
  parameter int AW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [W-1:0]      wr_data,
  output logic              run_q,
  output clr_sel_e          sel_q,
  output logic [NFLAGS-1:0] ien_q,
  output logic [W-1:0]      cmpa_q,
  output logic [W-1:0]      cmpb_q
);
  function automatic logic hit_addr(input logic [AW-1:0] a, input int unsigned r);
    return a == AW'(r);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      sel_q  <= CLR_NONE;
      ien_q  <= '0;
      cmpa_q <= '1;
      cmpb_q <= '1;
    end else if (wr_en) begin
      if (hit_addr(wr_addr, ADR_RUN))  run_q  <= wr_data[0];
      if (hit_addr(wr_addr, ADR_CTRL)) sel_q  <= clr_sel_e'(wr_data[1:0]);
      if (hit_addr(wr_addr, ADR_IEN))  ien_q  <= wr_data[NFLAGS-1:0];
      if (hit_addr(wr_addr, ADR_CMPA)) cmpa_q <= wr_data;
      if (hit_addr(wr_addr, ADR_CMPB)) cmpb_q <= wr_data;
    end
  end
endmodule

// File: rtl/tmr_counter.sv
`timescale 1ns/1ps
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] cmpa,
  input  logic [W-1:0] cmpb,
  input  clr_sel_e     sel,
  output logic [W-1:0] count_q,
  output logic         wrap,
  output logic         hit_a,
  output logic         hit_b,
  output logic         clr_hit
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  function automatic logic [W-1:0] incr(input logic [W-1:0] v);
    return v + W'(1);
  endfunction

  function automatic logic want_clear(input clr_sel_e s, input logic a, input logic b);
    case (s)
      CLR_ON_A: return a;
      CLR_ON_B: return b;
      default:  return 1'b0;
    endcase
  endfunction

  logic [W-1:0] nxt;
  assign nxt     = incr(count_q);
  assign wrap    = step && (count_q == TOP);
  assign hit_a   = step && (nxt == cmpa);
  assign hit_b   = step && (nxt == cmpb);
  assign clr_hit = want_clear(sel, hit_a, hit_b);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count_q <= '0;
    else if (load)   count_q <= load_val;
    else if (step)   count_q <= clr_hit ? '0 : nxt;
  end
endmodule

// File: rtl/tmr_flags.sv
`timescale 1ns/1ps
module tmr_flags
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NFLAGS-1:0] set,
  input  logic              clr_wr,
  input  logic [NFLAGS-1:0] keep,
  output logic [NFLAGS-1:0] flag_q
);
  for (genvar i = 0; i < NFLAGS; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         flag_q[i] <= 1'b0;
      else if (set[i])    flag_q[i] <= 1'b1;
      else if (clr_wr)    flag_q[i] <= flag_q[i] & keep[i];
    end
  end
endmodule

// File: rtl/tmr_channel.sv
`timescale 1ns/1ps
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int W  = 16,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_en,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data,
  output logic          irq
);
  logic              run_q;
  clr_sel_e          sel_q;
  logic [NFLAGS-1:0] ien_q;
  logic [W-1:0]      cmpa_q, cmpb_q, count_q;
  logic              cnt_wr, st_wr, step;
  logic              wrap, hit_a, hit_b, clr_hit;
  logic [NFLAGS-1:0] events, flag_q;

  assign cnt_wr = wr_en && (wr_addr == AW'(ADR_COUNT));
  assign st_wr  = wr_en && (wr_addr == AW'(ADR_STAT));
  assign step   = cnt_en && run_q && !cnt_wr;

  tmr_regs #(.W(W), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .run_q(run_q), .sel_q(sel_q), .ien_q(ien_q), .cmpa_q(cmpa_q), .cmpb_q(cmpb_q)
  );

  tmr_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(step), .load(cnt_wr), .load_val(wr_data),
    .cmpa(cmpa_q), .cmpb(cmpb_q), .sel(sel_q), .count_q(count_q),
    .wrap(wrap), .hit_a(hit_a), .hit_b(hit_b), .clr_hit(clr_hit)
  );

  always_comb begin
    events          = '0;
    events[FLG_OVF] = wrap;
    events[FLG_A]   = hit_a;
    events[FLG_B]   = hit_b;
  end

  tmr_flags u_flags (
    .clk(clk), .rst_n(rst_n), .set(events), .clr_wr(st_wr),
    .keep(wr_data[NFLAGS-1:0]), .flag_q(flag_q)
  );

  assign irq = |(flag_q & ien_q);

  always_comb begin
    rd_data = '0;
    case (int'(rd_addr))
      ADR_RUN:   rd_data[0]          = run_q;
      ADR_CTRL:  rd_data[1:0]        = sel_q;
      ADR_STAT:  rd_data[NFLAGS-1:0] = flag_q;
      ADR_IEN:   rd_data[NFLAGS-1:0] = ien_q;
      ADR_COUNT: rd_data             = count_q;
      ADR_CMPA:  rd_data             = cmpa_q;
      ADR_CMPB:  rd_data             = cmpb_q;
      default:   rd_data             = '0;
    endcase
  end
endmodule

// File: rtl/tmr_channel_chk.sv
`timescale 1ns/1ps
module tmr_channel_chk
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              step,
  input logic              cnt_wr,
  input logic              st_wr,
  input logic              wrap,
  input logic              hit_a,
  input logic              hit_b,
  input clr_sel_e          sel,
  input logic [W-1:0]      count,
  input logic [NFLAGS-1:0] flags
);
  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !cnt_wr) |=> $stable(count));

  a_r3_wrap_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> flags[FLG_OVF]);

  a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !cnt_wr) |=> (count == '0));

  a_r4_match_a_flag: assert property (@(posedge clk) disable iff (!rst_n)
    hit_a |=> flags[FLG_A]);

  a_r4_match_b_flag: assert property (@(posedge clk) disable iff (!rst_n)
    hit_b |=> flags[FLG_B]);

  a_r5_clear_on_a: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_a && sel == CLR_ON_A) |=> (count == '0));

  a_r6_clear_on_b: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_b && sel == CLR_ON_B) |=> (count == '0));

  a_r7_sticky_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[FLG_OVF] && !st_wr) |=> flags[FLG_OVF]);

  a_r7_sticky_a: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[FLG_A] && !st_wr) |=> flags[FLG_A]);

  a_r7_sticky_b: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[FLG_B] && !st_wr) |=> flags[FLG_B]);

  a_r9_write_blocks_step: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |-> !step);
endmodule

bind tmr_channel tmr_channel_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .step(step), .cnt_wr(cnt_wr), .st_wr(st_wr),
  .wrap(wrap), .hit_a(hit_a), .hit_b(hit_b), .sel(sel_q),
  .count(count_q), .flags(flag_q)
);

// File: tb/tb_tmr_channel.sv
`timescale 1ns/1ps
module tb_tmr_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int          q_addr[$];
  logic [15:0] q_exp[$];
  string       q_tag[$];

  always #4 clk = ~clk;

  tmr_channel dut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  // Monitor: pops expected items and compares them with the ports.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (q_addr.size() > 0) begin
        int          a;
        logic [15:0] e, act;
        string       t;
        a = q_addr.pop_front();
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        if (a < 0) begin
          #0.2;
          act = {15'b0, irq};
        end else begin
          rd_addr = 3'(a);
          #0.2;
          act = rd_data;
        end
        checks++;
        if (act !== e) begin
          errors++;
          $display("FAIL %s addr=%0d actual=%h expected=%h", t, a, act, e);
        end
      end
    end
  end

  task automatic expect_rd(input int a, input logic [15:0] e, input string t);
    q_addr.push_back(a);
    q_exp.push_back(e);
    q_tag.push_back(t);
  endtask

  task automatic drain();
    @(negedge clk);
    #3;
  endtask

  task automatic wr(input int a, input logic [15:0] d, input logic ce = 1'b0);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = d; cnt_en = ce;
    @(negedge clk);
    wr_en = 1'b0; cnt_en = 1'b0;
  endtask

  task automatic pulse(input int n);
    @(negedge clk);
    cnt_en = 1'b1;
    repeat (n) @(negedge clk);
    cnt_en = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    expect_rd(4, 16'h0000, "R1 count");
    expect_rd(5, 16'hFFFF, "R1 cmpa");
    expect_rd(6, 16'hFFFF, "R1 cmpb");
    expect_rd(-1, 16'h0, "R1 irq");
    drain();
    expect_rd(0, 16'h0, "R1 run");
    expect_rd(1, 16'h0, "R1 ctrl");
    expect_rd(2, 16'h0, "R1 status");
    expect_rd(3, 16'h0, "R1 ien");
    drain();

    // R2 gating by run bit and strobe
    pulse(5);
    expect_rd(4, 16'd0, "R2 stopped");
    drain();
    wr(0, 16'h1);
    pulse(5);
    expect_rd(4, 16'd5, "R2 five steps");
    drain();
    repeat (3) @(negedge clk);
    expect_rd(4, 16'd5, "R2 no strobe");
    drain();

    // R9 counter write wins over a step in the same cycle
    wr(4, 16'hFFFD, 1'b1);
    expect_rd(4, 16'hFFFD, "R9 load");
    drain();

    // R3 wrap, R4 matches at FFFF (both compares at reset value)
    pulse(3);
    expect_rd(4, 16'h0000, "R3 wrapped");
    expect_rd(2, 16'h0007, "R3 R4 status");
    expect_rd(-1, 16'h0, "R8 no enable");
    drain();
    wr(3, 16'h1);
    expect_rd(-1, 16'h1, "R8 ovf enabled");
    drain();
    pulse(2);
    expect_rd(4, 16'd2, "R3 continues");
    drain();

    // R7 selective clear
    wr(2, 16'h0006);
    expect_rd(2, 16'h0006, "R7 clear ovf only");
    expect_rd(-1, 16'h0, "R8 ovf cleared");
    drain();
    wr(2, 16'h0000);
    expect_rd(2, 16'h0000, "R7 clear all");
    drain();
    // R7 set wins over clearing write
    wr(5, 16'd5);
    wr(4, 16'd4);
    wr(2, 16'h0000, 1'b1);
    expect_rd(4, 16'd5, "R7 step during write");
    expect_rd(2, 16'h0002, "R7 set wins");
    drain();

    // R5 periodic on A
    wr(2, 16'h0);
    wr(1, 16'h1);
    wr(5, 16'd3);
    wr(4, 16'd0);
    pulse(3);
    expect_rd(4, 16'd0, "R5 cleared at A");
    expect_rd(2, 16'h0002, "R5 flag A");
    drain();
    pulse(2);
    expect_rd(4, 16'd2, "R5 restart");
    drain();
    pulse(1);
    expect_rd(4, 16'd0, "R5 second period");
    drain();

    // R6 periodic on B, A matches without clearing
    wr(2, 16'h0);
    wr(1, 16'h2);
    wr(5, 16'd2);
    wr(6, 16'd4);
    wr(4, 16'd0);
    pulse(2);
    expect_rd(4, 16'd2, "R6 A no clear");
    expect_rd(2, 16'h0002, "R4 R6 flag A");
    drain();
    pulse(2);
    expect_rd(4, 16'd0, "R6 cleared at B");
    expect_rd(2, 16'h0006, "R6 flag B");
    drain();

    // R6 select 11 never clears
    wr(2, 16'h0);
    wr(1, 16'h3);
    wr(6, 16'd2);
    wr(4, 16'd0);
    pulse(3);
    expect_rd(4, 16'd3, "R6 sel 11 no clear");
    expect_rd(2, 16'h0006, "R4 both match");
    drain();

    // R8 irq from compare A enable
    wr(3, 16'h2);
    expect_rd(-1, 16'h1, "R8 A enabled");
    drain();
    wr(2, 16'h0004);
    expect_rd(-1, 16'h0, "R8 A cleared");
    expect_rd(2, 16'h0004, "R7 B kept");
    drain();

    // R10 read mux
    expect_rd(7, 16'h0000, "R10 unused");
    expect_rd(3, 16'h0002, "R10 ien");
    expect_rd(0, 16'h0001, "R10 run");
    expect_rd(1, 16'h0003, "R10 ctrl");
    drain();

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule